// File: doc/BRIEF.md
# Sequential Integer Divider

This unit performs integer division for a processor execute stage. One request carries two operands and a three-bit operation code. The code picks signed or unsigned arithmetic, quotient or remainder, and either the full operand width or a word form that uses only the low half of each operand. The unit returns one result, at the full width, through a valid/ready handshake. It holds `busy_o` high while it iterates.

A single unsigned restoring core produces one quotient bit per cycle. Signed requests are reduced to magnitudes before the core, and the signs are applied to the results afterwards. Division by zero and signed overflow never trap. The unit detects both at issue and returns a fixed answer without iterating.

After each iterated division the unit keeps both the final quotient and the final remainder. A later request with the same operands, the same width and the same signedness is answered from this store in one cycle. This covers the common case of a quotient followed by a remainder on the same operands.

Top module: `iter_div`

## Requirements
- R1: The operation code is encoded as op_i[0]=1 for remainder (0 for quotient), op_i[1]=1 for unsigned (0 for signed), and op_i[2]=1 for the word form (0 for full width). In unsigned full-width mode the quotient is floor(a/b) and the remainder is a mod b.
- R2: In signed mode the quotient truncates toward zero and a nonzero remainder carries the sign of the dividend.
- R3: When the divisor is zero, the quotient has every bit set and the remainder equals the dividend. This holds for both signed and unsigned operation.
- R4: In signed mode, dividing the most negative value of the operating width by -1 returns the dividend as the quotient and zero as the remainder.
- R5: The word forms use only the low XLEN/2 bits of each operand, taken as signed or unsigned per op_i[1]. The XLEN/2-bit result is sign-extended to XLEN bits in every case, including unsigned results and divide-by-zero results.
- R6: For a zero divisor or a signed overflow, out_valid_o rises in the cycle right after the accepting cycle. An iterated request raises out_valid_o a further XLEN cycles later in full-width mode and XLEN/2 cycles later in word mode.
- R7: in_ready_o is high only while the unit is idle. busy_o is high during the iteration. While out_valid_o is high and out_ready_i is low, result_o stays unchanged. A handshake on the output returns the unit to idle.
- R8: A request whose operands and op_i[2:1] match the last iterated request is answered in the cycle right after acceptance, with the stored quotient or remainder.
- R9: While rst_ni is low, out_valid_o and busy_o are low and in_ready_o is high. Reset also empties the result store, so the next request iterates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Unit idle, request accepted |
| op_i | input | 3 | Operation code: bit0 remainder, bit1 unsigned, bit2 word form |
| a_i | input | XLEN | Dividend |
| b_i | input | XLEN | Divisor |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result consumer ready |
| result_o | output | XLEN | Quotient or remainder |
| busy_o | output | 1 | Iteration in progress |

## Verification
The bench uses XLEN=8. It runs all eight operation codes over dividends and divisors that cover every low-nibble pattern, the values around the signed midpoint, and the top of the range. This separates sign handling from magnitude errors and word truncation from full-width behaviour. The zero divisor, the most-negative/-1 pair and unsigned word results with bit 3 set each land in their own result class. Because each quotient is followed by a remainder on the same operands, the measured latency shows whether the result store was hit or the request iterated. Occasional output stalls and a reset in the middle of the run check stability of the held result and clearing of the store.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_HOLD
  } div_state_e;

  localparam int unsigned OP_REM_BIT  = 0;
  localparam int unsigned OP_UNS_BIT  = 1;
  localparam int unsigned OP_WORD_BIT = 2;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int unsigned XLEN = 64
) (
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] a_ext_o,
  output logic [XLEN-1:0] dvd_mag_o,
  output logic [XLEN-1:0] dvs_mag_o,
  output logic            neg_q_o,
  output logic            neg_r_o,
  output logic            div0_o,
  output logic            ovf_o
);
  import div_pkg::*;
  localparam int unsigned HALF = XLEN / 2;

  logic            sgn, word, a_neg, b_neg;
  logic [XLEN-1:0] b_ext, min_val;

  always_comb begin
    sgn  = ~op_i[OP_UNS_BIT];
    word = op_i[OP_WORD_BIT];
    if (word) begin
      a_ext_o = {{HALF{sgn & a_i[HALF-1]}}, a_i[HALF-1:0]};
      b_ext   = {{HALF{sgn & b_i[HALF-1]}}, b_i[HALF-1:0]};
      min_val = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};
    end else begin
      a_ext_o = a_i;
      b_ext   = b_i;
      min_val = {1'b1, {(XLEN-1){1'b0}}};
    end
    a_neg     = sgn & a_ext_o[XLEN-1];
    b_neg     = sgn & b_ext[XLEN-1];
    dvd_mag_o = a_neg ? -a_ext_o : a_ext_o;
    dvs_mag_o = b_neg ? -b_ext : b_ext;
    div0_o    = (b_ext == '0);
    ovf_o     = sgn & (a_ext_o == min_val) & (b_ext == '1);
    neg_q_o   = a_neg ^ b_neg;
    neg_r_o   = a_neg;
  end

  always_comb begin
    assert_excl_special_R4: assert (!(div0_o && ovf_o));
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0] dvs_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned CW   = $clog2(XLEN + 1);

  logic [XLEN-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN:0]   shifted;
  logic            ge;
  logic [XLEN-1:0] rem_nxt, quo_nxt;

  always_comb begin
    shifted = {rem_q, quo_q[XLEN-1]};
    ge      = shifted >= {1'b0, dvs_q};
    rem_nxt = ge ? (shifted[XLEN-1:0] - dvs_q) : shifted[XLEN-1:0];
    quo_nxt = {quo_q[XLEN-2:0], ge};
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = busy_o && (cnt_q == CW'(1));
  assign quo_o  = quo_nxt;
  assign rem_o  = rem_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      rem_q <= '0;
      quo_q <= word_i ? (dvd_i << HALF) : dvd_i;
      dvs_q <= dvs_i;
      cnt_q <= word_i ? CW'(HALF) : CW'(XLEN);
    end else if (busy_o) begin
      rem_q <= rem_nxt;
      quo_q <= quo_nxt;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // restoring invariant: partial remainder stays below divisor
  assert_rem_below_dvs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rem_q < dvs_q);
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q <= CW'(XLEN));
  assert_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/div_fixup.sv
module div_fixup #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] mag_i,
  input  logic            neg_i,
  input  logic            word_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned HALF = XLEN / 2;
  logic [XLEN-1:0] signed_val;

  always_comb begin
    signed_val = neg_i ? -mag_i : mag_i;
    res_o      = word_i ? {{HALF{signed_val[HALF-1]}}, signed_val[HALF-1:0]} : signed_val;
  end
endmodule

// File: rtl/iter_div.sv
module iter_div #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [XLEN-1:0] result_o,
  output logic            busy_o
);
  import div_pkg::*;

  div_state_e      state_q;
  logic [XLEN-1:0] a_ext, dvd_mag, dvs_mag;
  logic            neg_q, neg_r, div0, ovf, special, hit, accept, start;
  logic            core_busy, core_done;
  logic [XLEN-1:0] core_quo, core_rem;

  logic            rem_sel_q, word_q, negq_q, negr_q;
  logic [XLEN-1:0] res_q;
  logic            last_vld_q;
  logic [XLEN-1:0] last_a_q, last_b_q, last_quo_q, last_rem_q;
  logic [1:0]      last_mode_q;

  logic            running;
  logic [XLEN-1:0] q_mag, r_mag, fix_q, fix_r;
  logic            q_neg, r_neg, fix_word;

  div_prep #(.XLEN(XLEN)) prep_i (
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .a_ext_o   (a_ext),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .neg_q_o   (neg_q),
    .neg_r_o   (neg_r),
    .div0_o    (div0),
    .ovf_o     (ovf)
  );

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_HOLD);
  assign busy_o      = core_busy;
  assign result_o    = res_q;
  assign accept      = in_valid_i && in_ready_o;
  assign special     = div0 || ovf;
  assign hit         = last_vld_q && (a_i == last_a_q) && (b_i == last_b_q)
                       && (op_i[OP_WORD_BIT:OP_UNS_BIT] == last_mode_q);
  assign start       = accept && !hit && !special;
  assign running     = (state_q == ST_RUN);

  div_core #(.XLEN(XLEN)) core_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .word_i  (op_i[OP_WORD_BIT]),
    .dvd_i   (dvd_mag),
    .dvs_i   (dvs_mag),
    .busy_o  (core_busy),
    .done_o  (core_done),
    .quo_o   (core_quo),
    .rem_o   (core_rem)
  );

  // idle: fixed results for special cases; run: core results with sign fix-up
  always_comb begin
    if (running) begin
      q_mag    = core_quo;
      r_mag    = core_rem;
      q_neg    = negq_q;
      r_neg    = negr_q;
      fix_word = word_q;
    end else begin
      q_mag    = div0 ? '1 : a_ext;
      r_mag    = div0 ? a_ext : '0;
      q_neg    = 1'b0;
      r_neg    = 1'b0;
      fix_word = op_i[OP_WORD_BIT];
    end
  end

  div_fixup #(.XLEN(XLEN)) fix_quo_i (
    .mag_i  (q_mag),
    .neg_i  (q_neg),
    .word_i (fix_word),
    .res_o  (fix_q)
  );

  div_fixup #(.XLEN(XLEN)) fix_rem_i (
    .mag_i  (r_mag),
    .neg_i  (r_neg),
    .word_i (fix_word),
    .res_o  (fix_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      res_q       <= '0;
      rem_sel_q   <= 1'b0;
      word_q      <= 1'b0;
      negq_q      <= 1'b0;
      negr_q      <= 1'b0;
      last_vld_q  <= 1'b0;
      last_a_q    <= '0;
      last_b_q    <= '0;
      last_mode_q <= '0;
      last_quo_q  <= '0;
      last_rem_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (hit) begin
            res_q   <= op_i[OP_REM_BIT] ? last_rem_q : last_quo_q;
            state_q <= ST_HOLD;
          end else if (special) begin
            res_q   <= op_i[OP_REM_BIT] ? fix_r : fix_q;
            state_q <= ST_HOLD;
          end else begin
            rem_sel_q   <= op_i[OP_REM_BIT];
            word_q      <= op_i[OP_WORD_BIT];
            negq_q      <= neg_q;
            negr_q      <= neg_r;
            last_vld_q  <= 1'b0;
            last_a_q    <= a_i;
            last_b_q    <= b_i;
            last_mode_q <= op_i[OP_WORD_BIT:OP_UNS_BIT];
            state_q     <= ST_RUN;
          end
        end
        ST_RUN: if (core_done) begin
          res_q      <= rem_sel_q ? fix_r : fix_q;
          last_quo_q <= fix_q;
          last_rem_q <= fix_r;
          last_vld_q <= 1'b1;
          state_q    <= ST_HOLD;
        end
        ST_HOLD: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o));
  assert_busy_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !in_ready_o);
  assert_special_fast_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && special |=> out_valid_o);
  assert_div0_quo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && div0 && !op_i[OP_REM_BIT] |=> result_o == '1);
  assert_hit_fast_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && hit |=> out_valid_o);
endmodule

// File: tb/iter_div_tb_top.sv
module iter_div_tb_top;
  localparam int unsigned XLEN = 8;
  localparam int unsigned HALF = XLEN / 2;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [2:0]      op_i = '0;
  logic [XLEN-1:0] a_i = '0;
  logic [XLEN-1:0] b_i = '0;
  logic            out_valid_o;
  logic            out_ready_i = 1'b0;
  logic [XLEN-1:0] result_o;
  logic            busy_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int op_count = 0;

  bit              key_vld = 1'b0;
  logic [XLEN-1:0] key_a, key_b;
  logic [1:0]      key_mode;

  iter_div #(.XLEN(XLEN)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .op_i        (op_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .result_o    (result_o),
    .busy_o      (busy_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      report();
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (op=%0d a=0x%0h b=0x%0h)",
               tag, got, exp, op_i, a_i, b_i);
    end
  endtask

  // reference from the requirements; cls: 1..5 result class
  function automatic logic [XLEN-1:0] ref_res(input logic [2:0] op, input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b, output bit sp,
                                              output string tag);
    int w, av, bv, q, r, res;
    logic [XLEN-1:0] t;
    w = op[2] ? HALF : XLEN;
    if (op[1]) begin
      av = op[2] ? int'(a[HALF-1:0]) : int'(a);
      bv = op[2] ? int'(b[HALF-1:0]) : int'(b);
    end else begin
      av = op[2] ? int'($signed(a[HALF-1:0])) : int'($signed(a));
      bv = op[2] ? int'($signed(b[HALF-1:0])) : int'($signed(b));
    end
    sp = 1'b1;
    if (bv == 0) begin
      q = -1; r = av; tag = "R3";
    end else if (!op[1] && av == -(1 << (w - 1)) && bv == -1) begin
      q = av; r = 0; tag = "R4";
    end else begin
      sp = 1'b0;
      q = av / bv; r = av % bv;
      tag = op[2] ? "R5" : (op[1] ? "R1" : "R2");
    end
    res = op[0] ? r : q;
    t = res[XLEN-1:0];
    if (op[2]) t = {{HALF{res[HALF-1]}}, res[HALF-1:0]};
    return t;
  endfunction

  function automatic logic [XLEN-1:0] pick(input int i);
    if (i < 16) return XLEN'(i);
    if (i < 24) return XLEN'(120 + i - 16);
    return XLEN'(248 + i - 24);
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input bit stall);
    logic [XLEN-1:0] exp;
    logic [XLEN-1:0] held;
    bit sp, hit;
    string tag;
    int lat, exp_lat;
    exp = ref_res(op, a, b, sp, tag);
    hit = key_vld && a == key_a && b == key_b && op[2:1] == key_mode;
    exp_lat = (sp || hit) ? 0 : (op[2] ? HALF : XLEN);
    @(negedge clk_i);
    check("R7 in_ready idle", int'(in_ready_o), 1);
    op_i = op; a_i = a; b_i = b; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    if (exp_lat != 0) check("R7 busy while iterating", int'({busy_o, in_ready_o}), 2);
    lat = 0;
    while (!out_valid_o) begin
      @(negedge clk_i);
      lat++;
    end
    check(hit ? "R8 latency" : "R6 latency", lat, exp_lat);
    check(tag, int'(result_o), int'(exp));
    if (stall) begin
      held = result_o;
      @(negedge clk_i);
      @(negedge clk_i);
      check("R7 held result", int'({out_valid_o, result_o}), int'({1'b1, held}));
    end
    out_ready_i = 1'b1;
    @(negedge clk_i);
    out_ready_i = 1'b0;
    check("R7 released", int'({out_valid_o, in_ready_o}), 1);
    if (!sp && !hit) begin
      key_vld = 1'b1; key_a = a; key_b = b; key_mode = op[2:1];
    end
    op_count++;
  endtask

  initial begin
    #22;
    check("R9 reset state", int'({out_valid_o, busy_o, in_ready_o}), 1);
    rst_ni = 1'b1;
    // R1..R5 sweep; quotient then remainder exercises R8 reuse
    for (int ai = 0; ai < 32; ai++) begin
      for (int bi = 0; bi < 32; bi++) begin
        for (int op = 0; op < 8; op++) begin
          do_op(3'(op), pick(ai), pick(bi), (op_count % 13) == 0);
        end
      end
    end
    // R9: reset during iteration clears outputs and result store
    do_op(3'b000, 8'd100, 8'd7, 1'b0);
    @(negedge clk_i);
    op_i = 3'b010; a_i = 8'd200; b_i = 8'd9; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 reset mid-run", int'({out_valid_o, busy_o, in_ready_o}), 1);
    rst_ni = 1'b1;
    key_vld = 1'b0;
    do_op(3'b001, 8'd100, 8'd7, 1'b0);
    report();
  end
endmodule